// File: doc/BRIEF.md
# DSP-Mode PCM Serial Engine

This block is the serial end of a PCM audio port that runs as clock master. It moves one 16-bit mono sample per frame in each direction. A clock generator outside the block supplies three single-cycle strobes in the system clock domain. The lead strobe marks the bit-clock edge where transmit data changes. The trail strobe marks the opposite edge, where receive data is sampled. The frame-sync flag is valid together with a lead strobe and marks the first slot of a frame. Sample storage sits outside the block. The engine pulls a word from a first-word-fall-through transmit queue and pushes each captured word to a receive queue.

Each direction has its own alignment bit. With the bit set, the MSB goes out one bit clock after the frame-sync slot. With it clear, the MSB goes out in the frame-sync slot itself. The port is active while either direction is enabled, and it drops to an idle, cleared state only when both are disabled. Slots are numbered from 0, where slot 0 is the bit clock that begins with the lead strobe carrying frame sync.

Top module: `pcm_dsp_engine`

## Requirements
- R1: `tx_pop` is high for exactly the cycle in which `lead_stb`, `fsync` and `tx_en` are high and `tx_empty` is low. The value on `tx_data` in that cycle is the word sent in the frame.
- R2: Transmit data goes MSB first. With `tx_late`=1, bit i of the word is on `sdo` during slot 16-i and `sdo` is 0 during slot 0. With `tx_late`=0, bit i is on `sdo` during slot 15-i.
- R3: After the last data bit, `sdo` is 0 in every slot until the next frame sync.
- R4: `sdo` changes only on the clock edge that samples `lead_stb` high (or when the port goes idle). It holds its value through the rest of the slot.
- R5: If `tx_empty` is high at frame sync while `tx_en` is high, there is no pop, `tx_starve` pulses for that one cycle, and the whole frame carries zeros.
- R6: With `rx_late`=1, `sdi` is sampled at the trail strobes of slots 1 to 16. With `rx_late`=0, it is sampled in slots 0 to 15. The first sample is bit 15. `rx_push` pulses once per frame, one cycle after the last sample, with the assembled word on `rx_data`. `sdi` outside the window is ignored.
- R7: The alignment bits are sampled at frame sync, and each direction uses its own bit. A change later in the frame does not affect that frame.
- R8: A frame whose sync sees `tx_en` low gives no pop and no starve pulse, and `sdo` stays 0. Reception still runs if `rx_en` is high.
- R9: While `rx_en` is low, `rx_push` never pulses.
- R10: While both `tx_en` and `rx_en` are low, `sdo` and `rx_push` are 0 one cycle later and the engine ignores strobes. Normal frames resume at the next frame sync after the port is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_late | input | 1 | 1: transmit MSB one slot after sync; 0: in the sync slot |
| rx_late | input | 1 | 1: receive MSB one slot after sync; 0: in the sync slot |
| lead_stb | input | 1 | Bit-clock edge where transmit data changes |
| trail_stb | input | 1 | Opposite bit-clock edge, where receive data is sampled |
| fsync | input | 1 | Frame sync, valid with `lead_stb` |
| tx_data | input | WORD_W | Head word of the transmit queue |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_pop | output | 1 | Takes the head word of the transmit queue |
| tx_starve | output | 1 | Frame started with the transmit queue empty |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_data | output | WORD_W | Captured word, valid with `rx_push` |
| rx_push | output | 1 | Writes `rx_data` to the receive queue |

## Verification
The bench runs frames with every pairing of the two alignment bits. It drives ones on `sdi` outside the receive window. A design that mixed up the two directions' alignment bits, or counted the window one slot off, would shift the word by one bit or take in those stray ones. One frame flips both alignment bits just after sync. A design that reads the bits live instead of latching them would reshape that frame. Frames with an empty queue, with one direction off and with both off show whether a design still pops, fails to flag starvation, leaves stale bits on the line, or pushes words it should have dropped.

// File: rtl/pcm_dsp_engine.sv
module pcm_dsp_engine #(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_late,
  input  logic              rx_late,
  input  logic              lead_stb,
  input  logic              trail_stb,
  input  logic              fsync,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              tx_starve,
  output logic              sdo,
  input  logic              sdi,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_push
);
  localparam int SW = $clog2(SLOTS);

  logic              run, sync_hit, in_win, last_bit;
  logic [WORD_W-1:0] load, tx_sh, rx_sh;
  logic [SW-1:0]     slot, first;
  logic              framed, rx_late_q;

  assign run       = tx_en | rx_en;
  assign sync_hit  = run & lead_stb & fsync;
  assign tx_pop    = sync_hit & tx_en & ~tx_empty;
  assign tx_starve = sync_hit & tx_en & tx_empty;
  assign load      = tx_pop ? tx_data : '0;

  assign first    = SW'(rx_late_q);
  assign in_win   = (slot >= first) && (int'(slot) <= int'(first) + WORD_W - 1);
  assign last_bit = int'(slot) == int'(first) + WORD_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      tx_sh     <= '0;
      sdo       <= 1'b0;
      slot      <= '0;
      framed    <= 1'b0;
      rx_late_q <= 1'b0;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_push   <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (lead_stb) begin
        if (fsync) begin
          slot      <= '0;
          framed    <= 1'b1;
          rx_late_q <= rx_late;
          if (tx_late) begin
            sdo   <= 1'b0;
            tx_sh <= load;
          end else begin
            sdo   <= load[WORD_W-1];
            tx_sh <= {load[WORD_W-2:0], 1'b0};
          end
        end else begin
          slot  <= (int'(slot) == SLOTS - 1) ? slot : slot + 1'b1;
          sdo   <= tx_sh[WORD_W-1];
          tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
      end
      if (trail_stb && framed && rx_en && in_win) begin
        rx_sh <= {rx_sh[WORD_W-2:0], sdi};
        if (last_bit) begin
          rx_push <= 1'b1;
          rx_data <= {rx_sh[WORD_W-2:0], sdi};
        end
      end
    end
  end
endmodule

module pcm_dsp_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic lead_stb,
  input logic trail_stb,
  input logic fsync,
  input logic tx_empty,
  input logic tx_pop,
  input logic tx_starve,
  input logic sdo,
  input logic rx_push
);
  assert_pop_on_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (lead_stb && fsync && tx_en));

  assert_no_pop_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  assert_pop_starve_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pop && tx_starve));

  assert_sdo_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_en || rx_en) && !lead_stb) |=> $stable(sdo));

  assert_push_after_trail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(trail_stb));

  assert_push_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  assert_no_push_rx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !$past(rx_en)) |-> !rx_push);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en || rx_en) |=> (!sdo && !rx_push));
endmodule

bind pcm_dsp_engine pcm_dsp_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
  .lead_stb(lead_stb), .trail_stb(trail_stb), .fsync(fsync),
  .tx_empty(tx_empty), .tx_pop(tx_pop), .tx_starve(tx_starve),
  .sdo(sdo), .rx_push(rx_push)
);

// File: tb/sim_pcm_dsp_engine.sv
module sim_pcm_dsp_engine;
  localparam int NS = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tx_en, rx_en, tx_late, rx_late, lead_stb, trail_stb, fsync;
  logic [15:0] tx_data, rx_data;
  logic tx_empty, tx_pop, tx_starve, sdo, sdi, rx_push;

  pcm_dsp_engine #(.WORD_W(16), .SLOTS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .tx_late(tx_late), .rx_late(rx_late), .lead_stb(lead_stb),
    .trail_stb(trail_stb), .fsync(fsync), .tx_data(tx_data),
    .tx_empty(tx_empty), .tx_pop(tx_pop), .tx_starve(tx_starve),
    .sdo(sdo), .sdi(sdi), .rx_data(rx_data), .rx_push(rx_push)
  );

  int checks = 0, fails = 0, push_cnt = 0;
  bit done = 0;
  logic [15:0] rxq[$];
  logic [15:0] mon_e;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      push_cnt++;
      if (rxq.size() == 0) chk(0, "R9", "unexpected rx push", rx_data, 0);
      else begin
        mon_e = rxq.pop_front();
        chk(rx_data == mon_e, "R6", "received word", rx_data, mon_e);
      end
    end
  end

  function automatic logic rbit(input logic [15:0] w, input bit late, input int s);
    int idx;
    idx = s - int'(late);
    return (idx >= 0 && idx < 16) ? w[15-idx] : 1'b1;
  endfunction

  task automatic run_frame(input logic [15:0] tw, input bit tempty, input bit tlate,
                           input logic [15:0] rw, input bit rlate, input bit flip,
                           input string wtag, input string rtag);
    logic [15:0] ew, got;
    int tail_bad, stab_bad, p0, idx;
    bit sv, txon, rxon;
    txon = tx_en; rxon = rx_en;
    ew = (txon && !tempty) ? tw : 16'h0;
    got = 16'h0; tail_bad = 0; stab_bad = 0; sv = 0;
    if (rxon) rxq.push_back(rw);
    p0 = push_cnt;
    tx_late = tlate; rx_late = rlate; tx_data = tw; tx_empty = tempty;
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        lead_stb = (p == 0); trail_stb = (p == 2); fsync = (p == 0 && s == 0);
        if (p == 0) sdi = rbit(rw, rlate, s);
        if (flip && s == 3 && p == 0) begin tx_late = ~tlate; rx_late = ~rlate; end
        if (s == 0 && p == 0) begin
          #1;
          chk(tx_pop == (txon && !tempty), (txon ? "R1" : "R8"), "pop at sync", tx_pop, txon && !tempty);
          chk(tx_starve == (txon && tempty), (txon ? "R5" : "R8"), "starve at sync", tx_starve, txon && tempty);
        end
        if (p == 2) begin
          idx = s - int'(tlate);
          if (idx >= 0 && idx < 16) got[15-idx] = sdo;
          else if (sdo) tail_bad++;
          sv = sdo;
        end
        if (p == 3 && sdo != sv) stab_bad++;
      end
    end
    @(negedge clk);
    lead_stb = 0; trail_stb = 0; fsync = 0;
    chk(got == ew, wtag, "transmitted word", got, ew);
    chk(tail_bad == 0, "R3", "nonzero slots outside data", tail_bad, 0);
    chk(stab_bad == 0, "R4", "sdo moved mid slot", stab_bad, 0);
    chk(push_cnt - p0 == (rxon ? 1 : 0), rtag, "pushes in frame", push_cnt - p0, rxon ? 1 : 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    #1_000_000;
    chk(0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; tx_en = 0; rx_en = 0; tx_late = 0; rx_late = 0;
    lead_stb = 0; trail_stb = 0; fsync = 0; tx_data = 0; tx_empty = 1; sdi = 0;
    repeat (3) @(negedge clk);
    chk(sdo == 0 && rx_push == 0 && tx_pop == 0, "R10", "reset outputs quiet",
        {sdo, rx_push, tx_pop}, 0);
    rst_n = 1; tx_en = 1; rx_en = 1;
    @(negedge clk);
    run_frame(16'hA5C3, 0, 0, 16'h1234, 0, 0, "R2", "R6");
    run_frame(16'h8001, 0, 1, 16'hFEDC, 1, 0, "R2", "R6");
    run_frame(16'h7F00, 0, 1, 16'h0F0F, 0, 0, "R7", "R7");
    run_frame(16'h3C96, 0, 0, 16'h8421, 1, 1, "R7", "R7");
    run_frame(16'hBEEF, 1, 0, 16'h5555, 0, 0, "R5", "R6");
    tx_en = 0;
    run_frame(16'h1111, 0, 0, 16'hAAAA, 1, 0, "R8", "R8");
    tx_en = 1; rx_en = 0;
    run_frame(16'h2222, 0, 1, 16'hFFFF, 0, 0, "R2", "R9");
    tx_en = 0; rx_en = 0;
    run_frame(16'h3333, 0, 0, 16'h7777, 0, 0, "R10", "R10");
    tx_en = 1; rx_en = 1;
    run_frame(16'h6E5A, 0, 1, 16'hC0DE, 1, 0, "R10", "R10");
    summary();
    $finish;
  end
endmodule